// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block is the configuration front end of a servo preprocessor. A host reaches it over a three-wire link: an enable line, a serial clock, and one data line that both sides can pull low. Each enable window carries one 16-bit word. The word holds a 5-bit port code and 8 data bits. When the word is accepted, its data bits are written into one of five configuration registers. The register contents leave the block as decoded control fields for the analog blocks, which are not part of this design.

The three wire inputs are synchronised to the system clock and oversampled. A state machine steps through four states:
- **IDLE**: the enable line is low.
- **SHIFT**: bits are collected on each falling serial-clock edge.
- **COMMIT**: a one-cycle write strobe after the 16th falling edge.
- **ACK**: the data line is held low until the enable line drops.

The transitions are:
- IDLE→SHIFT when enable rises.
- SHIFT→IDLE when enable drops early. The partial word is discarded.
- SHIFT→COMMIT on the 16th falling edge.
- COMMIT→ACK, or COMMIT→IDLE if enable is already low.
- ACK→IDLE when enable drops.

While the sleep code has its upper bit set, every field except the sleep bits is held at its default value.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, every field holds its default value and the pull-down is off. The defaults are all zero, except the phase coefficient code, which is 011.
- R2: The word is shifted in least-significant bit first. Each bit is taken on a falling serial-clock edge while enable is high.
  - Bits 15..8 carry the data and bits 6..2 carry the port code.
  - Port codes 2, 3, 4, 5 and 6 select ports A, B, C, D and E.
  - Port A data bits, from bit 7 down:
    - 7: output enable
    - 6: header force
    - 5: focus filter bypass
    - 4: tracking filter slow
    - 3..2: tracking select
    - 1..0: sleep
  - Port B data bits: 7..5 offset, 4..3 window, 2..0 hysteresis.
  - Port C data bits:
    - 7: tracking hold enable
    - 6: focus hold enable
    - 5: header run
    - 4..3: mono time
    - 2..0: slice
  - Port D data bits: 7 equalizer, 6..4 coefficient, 3..0 delay.
  - Port E data bits: 7..5 aux, 4..3 range. Bits 2..0 of port E are not stored.
- R3: An enable window with fewer than 16 falling edges changes no register and gives no acknowledge.
- R4: An enable window with more than 16 falling edges uses only the first 16 bits. Later bits have no effect.
- R5: After the 16th falling edge the pull-down turns on. It stays on while enable remains high, including during extra edges, and turns off once enable is low.
- R6: The pull-down stays off before the 16th falling edge of a window.
- R7: A word with a port code other than 2 to 6 is acknowledged and writes no register.
- R8: A sleep code of 10 or 11 returns every other field to its default value. The sleep bits keep the written code. Writes to any port during such sleep leave the fields at their defaults.
- R9: A port A write that sets the sleep code to 00 or 01 stores the other port A fields from the same word. A sleep code of 01 applies no preset.
- R10: Word bits 7, 1 and 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-on preset |
| ser_en_i | input | 1 | Serial enable, active high |
| ser_clk_i | input | 1 | Serial clock, data taken on falling edge |
| ser_dat_i | input | 1 | Sensed level of the shared data line |
| ser_dat_pull_o | output | 1 | Pull-down enable for the data line (acknowledge) |
| a_out_en_o | output | 1 | Port A output enable |
| a_hdr_force_o | output | 1 | Port A header force |
| a_foc_bypass_o | output | 1 | Port A focus filter bypass |
| a_trk_slow_o | output | 1 | Port A tracking filter slow |
| a_trk_sel_o | output | 2 | Port A tracking select |
| a_sleep_o | output | 2 | Port A sleep code |
| b_offset_o | output | 3 | Port B offset code |
| b_window_o | output | 2 | Port B window code |
| b_hyst_o | output | 3 | Port B hysteresis code |
| c_trk_hold_o | output | 1 | Port C tracking hold enable |
| c_foc_hold_o | output | 1 | Port C focus hold enable |
| c_hdr_run_o | output | 1 | Port C header run |
| c_mono_o | output | 2 | Port C mono time code |
| c_slice_o | output | 3 | Port C slice code |
| d_eq_on_o | output | 1 | Port D equalizer on |
| d_coef_o | output | 3 | Port D coefficient code |
| d_delay_o | output | 4 | Port D delay code |
| e_aux_o | output | 3 | Port E aux code |
| e_range_o | output | 2 | Port E range code |

## Verification
The bench builds the block with its default parameters:
- a 16-bit word,
- a 5-bit port code at bit 2,
- two synchroniser stages.

The bench's serial clock runs at twelve system clocks per period. At that rate the edge detector and the two-flop delay are exercised with real margin, and every word length is reachable: 15 edges (short), 16 edges (exact) and 20 edges (long).

A behavioural model of the five registers is compared on every quiet clock. Within that model, the sleep codes 01, 10 and 11 and the wake-up write reach the preset and precedence paths.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;

    localparam int FRAME_W   = 16;
    localparam int DATA_W    = 8;
    localparam int DATA_LSB  = 8;
    localparam int ADDR_W    = 5;
    localparam int ADDR_LSB  = 2;
    localparam int NUM_PORTS = 5;
    localparam int SLEEP_W   = 2;
    localparam int BASE_CODE = 2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SHIFT,
        S_COMMIT,
        S_ACK
    } frame_state_e;

    function automatic logic [ADDR_W-1:0] port_code(input int p);
        return ADDR_W'(p + BASE_CODE);
    endfunction

    function automatic logic [DATA_W-1:0] port_default(input int p);
        return (p == 3) ? DATA_W'(8'h30) : '0;
    endfunction

    function automatic logic [DATA_W-1:0] port_wmask(input int p);
        return (p == 4) ? DATA_W'(8'hF8) : '1;
    endfunction

    function automatic logic [NUM_PORTS*DATA_W-1:0] default_image();
        logic [NUM_PORTS*DATA_W-1:0] img;
        img = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            img[p*DATA_W +: DATA_W] = port_default(p);
        end
        return img;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ctl_frame_fsm.sv
module ctl_frame_fsm
    import ctl_serial_pkg::*;
#(
    parameter int FRM_W = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sclk_i,
    input  logic             sdat_i,
    output logic [FRM_W-1:0] frame_o,
    output logic             commit_o,
    output logic             pull_o
);

    localparam int CNT_W = $clog2(FRM_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRM_W - 1);

    frame_state_e st, st_nxt;
    logic             sclk_d;
    logic             fall;
    logic             last_edge;
    logic [CNT_W-1:0] cnt;
    logic [FRM_W-1:0] shreg;

    assign fall      = sclk_d & ~sclk_i;
    assign last_edge = (st == S_SHIFT) && en_i && fall && (cnt == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:   if (en_i) st_nxt = S_SHIFT;
            S_SHIFT: begin
                if (!en_i)          st_nxt = S_IDLE;
                else if (last_edge) st_nxt = S_COMMIT;
            end
            S_COMMIT: st_nxt = en_i ? S_ACK : S_IDLE;
            S_ACK:    if (!en_i) st_nxt = S_IDLE;
            default:  st_nxt = S_IDLE;
        endcase
    end

    // bit collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_d <= sclk_i;
            if (st == S_IDLE) begin
                cnt <= '0;
            end else if (st == S_SHIFT && en_i && fall) begin
                shreg <= {sdat_i, shreg[FRM_W-1:1]};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        pull_o   = 1'b0;
        unique case (st)
            S_IDLE:   ;
            S_SHIFT:  ;
            S_COMMIT: begin
                commit_o = 1'b1;
                pull_o   = 1'b1;
            end
            S_ACK:    pull_o = 1'b1;
            default:  ;
        endcase
    end

    assign frame_o = shreg;

endmodule

// File: rtl/ctl_cfg_regs.sv
module ctl_cfg_regs
    import ctl_serial_pkg::*;
#(
    parameter int NPORT = NUM_PORTS,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       data_i,
    output logic [NPORT*DW-1:0] regs_o
);

    logic [DW-1:0] cur [NPORT];
    logic [DW-1:0] wrv [NPORT];
    logic [DW-1:0] nxt [NPORT];
    logic          sleep_deep;

    for (genvar p = 0; p < NPORT; p++) begin : g_wr
        localparam logic [DW-1:0] DFLT = DW'(port_default(p));
        localparam logic [DW-1:0] MSK  = DW'(port_wmask(p));
        logic hit;
        assign hit    = wr_i && (addr_i == AW'(port_code(p)));
        assign wrv[p] = hit ? ((data_i & MSK) | (DFLT & ~MSK)) : cur[p];
    end

    assign sleep_deep = wrv[0][SLEEP_W-1];

    for (genvar p = 0; p < NPORT; p++) begin : g_reg
        localparam logic [DW-1:0] DFLT = DW'(port_default(p));
        if (p == 0) begin : g_ctl
            assign nxt[p] = sleep_deep ? {DFLT[DW-1:SLEEP_W], wrv[p][SLEEP_W-1:0]} : wrv[p];
        end else begin : g_plain
            assign nxt[p] = sleep_deep ? DFLT : wrv[p];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur[p] <= DFLT;
            end else begin
                cur[p] <= nxt[p];
            end
        end
        assign regs_o[p*DW +: DW] = cur[p];
    end

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_en_i,
    input  logic       ser_clk_i,
    input  logic       ser_dat_i,
    output logic       ser_dat_pull_o,
    output logic       a_out_en_o,
    output logic       a_hdr_force_o,
    output logic       a_foc_bypass_o,
    output logic       a_trk_slow_o,
    output logic [1:0] a_trk_sel_o,
    output logic [1:0] a_sleep_o,
    output logic [2:0] b_offset_o,
    output logic [1:0] b_window_o,
    output logic [2:0] b_hyst_o,
    output logic       c_trk_hold_o,
    output logic       c_foc_hold_o,
    output logic       c_hdr_run_o,
    output logic [1:0] c_mono_o,
    output logic [2:0] c_slice_o,
    output logic       d_eq_on_o,
    output logic [2:0] d_coef_o,
    output logic [3:0] d_delay_o,
    output logic [2:0] e_aux_o,
    output logic [1:0] e_range_o
);

    localparam int IMG_W = NUM_PORTS * DATA_W;

    logic [2:0]         raw_w, syn_w;
    logic               en_s, sclk_s, sdat_s;
    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic [IMG_W-1:0]   cfg;
    logic [2:0]         e_spare_unused;
    logic               dont_care_unused;

    assign raw_w = {ser_en_i, ser_clk_i, ser_dat_i};
    assign {en_s, sclk_s, sdat_s} = syn_w;

    ctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (syn_w)
    );

    ctl_frame_fsm #(.FRM_W(FRAME_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_s),
        .sclk_i   (sclk_s),
        .sdat_i   (sdat_s),
        .frame_o  (frame),
        .commit_o (commit),
        .pull_o   (ser_dat_pull_o)
    );

    ctl_cfg_regs #(.NPORT(NUM_PORTS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (commit),
        .addr_i (frame[ADDR_LSB +: ADDR_W]),
        .data_i (frame[DATA_LSB +: DATA_W]),
        .regs_o (cfg)
    );

    assign dont_care_unused = ^{frame[ADDR_LSB-1:0], frame[DATA_LSB-1:ADDR_LSB+ADDR_W]};

    assign {a_out_en_o, a_hdr_force_o, a_foc_bypass_o, a_trk_slow_o,
            a_trk_sel_o, a_sleep_o}                              = cfg[7:0];
    assign {b_offset_o, b_window_o, b_hyst_o}                    = cfg[15:8];
    assign {c_trk_hold_o, c_foc_hold_o, c_hdr_run_o, c_mono_o,
            c_slice_o}                                           = cfg[23:16];
    assign {d_eq_on_o, d_coef_o, d_delay_o}                      = cfg[31:24];
    assign {e_aux_o, e_range_o, e_spare_unused}                  = cfg[39:32];

endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
    import ctl_serial_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en_s,
    input logic                          commit,
    input logic                          pull,
    input logic [NUM_PORTS*DATA_W-1:0]   cfg
);

    localparam logic [NUM_PORTS*DATA_W-1:0] DFLT_IMG = default_image();

    AST_ACK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> commit);  // R6

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && en_s) |=> pull);  // R5

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && !en_s) |=> !pull);  // R5

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg));  // R3

    AST_SLEEP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[SLEEP_W-1] |-> (cfg[NUM_PORTS*DATA_W-1:SLEEP_W] == DFLT_IMG[NUM_PORTS*DATA_W-1:SLEEP_W]));  // R8

endmodule

bind ctl_serial_port ctl_serial_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_s   (en_s),
    .commit (commit),
    .pull   (ser_dat_pull_o),
    .cfg    (cfg)
);

// File: tb/ctl_serial_port_bench.sv
module ctl_serial_port_bench;

    localparam int SP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_clk = 1'b0, drv = 1'b1;
    logic pull, line;
    logic a_out_en, a_hdr, a_foc, a_trk;
    logic [1:0] a_sel, a_sleep, b_win, c_mono, e_range;
    logic [2:0] b_off, b_hys, c_slice, d_coef, e_aux;
    logic c_th, c_fh, c_hr, d_eq;
    logic [3:0] d_dly;

    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit    settled = 1'b0;
    bit    done = 1'b0;
    logic [7:0] exp_img [5];

    always #10 clk = ~clk;

    assign line = drv & ~pull;

    ctl_serial_port u_ctl_serial_port (
        .clk(clk), .rst_n(rst_n), .ser_en_i(ser_en), .ser_clk_i(ser_clk),
        .ser_dat_i(line), .ser_dat_pull_o(pull),
        .a_out_en_o(a_out_en), .a_hdr_force_o(a_hdr), .a_foc_bypass_o(a_foc),
        .a_trk_slow_o(a_trk), .a_trk_sel_o(a_sel), .a_sleep_o(a_sleep),
        .b_offset_o(b_off), .b_window_o(b_win), .b_hyst_o(b_hys),
        .c_trk_hold_o(c_th), .c_foc_hold_o(c_fh), .c_hdr_run_o(c_hr),
        .c_mono_o(c_mono), .c_slice_o(c_slice),
        .d_eq_on_o(d_eq), .d_coef_o(d_coef), .d_delay_o(d_dly),
        .e_aux_o(e_aux), .e_range_o(e_range)
    );

    function automatic logic [7:0] dflt(input int p);
        return (p == 3) ? 8'h30 : 8'h00;
    endfunction

    function automatic logic [7:0] observed(input int p);
        case (p)
            0:       return {a_out_en, a_hdr, a_foc, a_trk, a_sel, a_sleep};
            1:       return {b_off, b_win, b_hys};
            2:       return {c_th, c_fh, c_hr, c_mono, c_slice};
            3:       return {d_eq, d_coef, d_dly};
            default: return {e_aux, e_range, 3'b000};
        endcase
    endfunction

    function automatic logic [15:0] word(input logic [7:0] data, input logic [4:0] code,
                                         input logic [2:0] junk);
        return {data, junk[2], code, junk[1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    // behavioural model of an accepted word
    task automatic apply(input logic [15:0] w);
        int code = int'(w[6:2]);
        if (code >= 2 && code <= 6) begin
            int p = code - 2;
            exp_img[p] = (p == 4) ? (w[15:8] & 8'hF8) : w[15:8];
        end
        if (exp_img[0][1]) begin
            for (int p = 1; p < 5; p++) exp_img[p] = dflt(p);
            exp_img[0] = {6'b000000, exp_img[0][1:0]};
        end
    endtask

    task automatic send(input logic [31:0] bits, input int n, input string req);
        settled = 1'b0;
        cur_req = req;
        ser_en  = 1'b1;
        step(SP);
        for (int i = 0; i < n; i++) begin
            drv = bits[i];
            ser_clk = 1'b1;
            step(SP);
            ser_clk = 1'b0;
            step(SP);
            if (i == 14)
                check(pull == 1'b0, "R6", "pull before last edge", 64'(pull), 64'd0);
        end
        drv = 1'b1;
        if (n >= 16) begin
            check(pull == 1'b1, "R5", "ack after frame", 64'(pull), 64'd1);
            step(2 * SP);
            check(pull == 1'b1, "R5", "ack held", 64'(pull), 64'd1);
        end else begin
            check(pull == 1'b0, "R3", "no ack short frame", 64'(pull), 64'd0);
        end
        ser_en = 1'b0;
        step(8);
        check(pull == 1'b0, "R5", "ack released", 64'(pull), 64'd0);
        if (n >= 16) apply(bits[15:0]);
        settled = 1'b1;
        step(4);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (settled && !done) begin
            for (int p = 0; p < 5; p++) begin
                check(observed(p) == exp_img[p], cur_req, "model compare",
                      64'(observed(p)), 64'(exp_img[p]));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 5; p++) exp_img[p] = dflt(p);
        step(5);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        check(pull == 1'b0, "R1", "pull after reset", 64'(pull), 64'd0);
        check(d_coef == 3'b011, "R1", "coefficient default", 64'(d_coef), 64'd3);
        settled = 1'b1;
        step(10);

        // R2 each port written
        send(32'(word(8'hBC, 5'd2, 3'b000)), 16, "R2");
        check(a_sel == 2'b11 && a_out_en, "R2", "port A fields", 64'(observed(0)), 64'hBC);
        send(32'(word(8'hA5, 5'd3, 3'b000)), 16, "R2");
        send(32'(word(8'h6E, 5'd4, 3'b000)), 16, "R2");
        send(32'(word(8'hC9, 5'd5, 3'b000)), 16, "R2");
        check(d_dly == 4'h9 && d_coef == 3'b100, "R2", "port D fields", 64'(observed(3)), 64'hC9);
        send(32'(word(8'hFF, 5'd6, 3'b000)), 16, "R2");
        check(observed(4) == 8'hF8, "R2", "port E stored bits", 64'(observed(4)), 64'hF8);

        // R3 short frame
        send(32'(word(8'h00, 5'd5, 3'b000)), 15, "R3");
        check(d_dly == 4'h9, "R3", "short frame kept port D", 64'(d_dly), 64'h9);

        // R4 long frame, trailing bits would otherwise form another word
        send({16'hFFFF, word(8'h52, 5'd3, 3'b000)} & 32'h000F_FFFF, 20, "R4");
        check(observed(1) == 8'h52, "R4", "long frame port B", 64'(observed(1)), 64'h52);

        // R7 unknown codes
        send(32'(word(8'hFF, 5'd7, 3'b000)), 16, "R7");
        send(32'(word(8'hFF, 5'd0, 3'b000)), 16, "R7");

        // R10 don't-care bits
        send(32'(word(8'h1B, 5'd4, 3'b111)), 16, "R10");
        check(observed(2) == 8'h1B, "R10", "port C with junk bits", 64'(observed(2)), 64'h1B);

        // R9 light sleep, no preset
        send(32'(word(8'h55, 5'd2, 3'b000)), 16, "R9");
        check(a_sleep == 2'b01 && observed(1) == 8'h52, "R9", "sleep 01 no preset",
              64'(observed(1)), 64'h52);

        // R8 deep sleep presets
        send(32'(word(8'hF3, 5'd2, 3'b000)), 16, "R8");
        check(observed(0) == 8'h03 && d_coef == 3'b011, "R8", "sleep 11 preset",
              64'(observed(0)), 64'h03);
        send(32'(word(8'hE7, 5'd3, 3'b000)), 16, "R8");
        check(observed(1) == 8'h00, "R8", "write in sleep ignored", 64'(observed(1)), 64'h00);

        // R9 wake with fields in the same word
        send(32'(word(8'hD0, 5'd2, 3'b000)), 16, "R9");
        check(observed(0) == 8'hD0, "R9", "wake word fields", 64'(observed(0)), 64'hD0);
        send(32'(word(8'h77, 5'd5, 3'b000)), 16, "R9");

        // R8 sleep 10 also presets
        send(32'(word(8'h8E, 5'd2, 3'b000)), 16, "R8");
        check(observed(0) == 8'h02 && observed(3) == 8'h30, "R8", "sleep 10 preset",
              64'(observed(3)), 64'h30);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule